// File: doc/BRIEF.md
# Sector data field encoder

This block produces the data field of one disk sector as a serial bit stream for a write head driver. Software-side logic first loads the 256 sector bytes through a byte-wide load port. The loader stores each byte split in two: the upper six bits go to a 256-entry primary store, and the lower two bits go into one of 86 six-bit auxiliary entries.

A start pulse then launches the field. If the write-protect input is high at that moment, the block reports a fault and writes nothing. Otherwise it sends, in order:

- five ten-bit sync bytes;
- a three-byte prologue;
- 342 group-coded data bytes;
- one checksum byte;
- a three-byte epilogue;
- one trailing sync byte.

Each group-coded byte comes from a 64-entry translation of a six-bit value. That value is the XOR of two neighbouring stored entries. One bit leaves per pulse of the bit-cell strobe, most significant bit first. The write-enable output frames the whole stream.

Top module: `sector_data_encoder`

## Requirements
- R1: When start is pulsed while idle with wprot high, fault is high for the one cycle after the start edge. busy stays low, wr_en stays low, and no bit is written.
- R2: The stream opens with exactly five ten-bit sync words. Each is eight 1 bits followed by two 0 bits. The prologue bytes D5, AA, AD follow.
- R3: Next come 86 bytes for auxiliary entries k = 85 down to 0. Entry 85 is XORed with 0. Every later entry k is XORed with entry k+1.
- R4: Next come 256 bytes for primary entries i = 0 up to 255. The first value is aux[0] XOR pri[0]. Every later value is pri[i-1] XOR pri[i].
- R5: A six-bit value v becomes the v-th smallest byte (counting from 0) that meets three conditions. Bit 7 is set. At most one pair of adjacent bit positions are both 0. At least one pair of adjacent 1 bits lies within bits 6..0. So 0 maps to 96 and 63 maps to FF.
- R6: After the data bytes come the checksum (the translation of pri[255]), then DE, AA, EB, then one ten-bit sync word. The stream totals 2852 bits.
- R7: A loaded byte b at address a sets pri[a] = b[7:2]. It also sets bits [2g+1:2g] of aux[a mod 86] to {b[0], b[1]}, where g = a div 86. Groups with no source byte read as 0.
- R8: wr_bit changes only on a cycle after a cell_stb cycle, and the bits leave most significant bit first. wr_en rises with the first bit and falls at the strobe after the last bit. done pulses once afterwards, with wr_en and busy low.
- R9: A start pulse while busy has no effect. The stream in progress is unchanged and no fault is raised.
- R10: With all stored bytes zero, all 342 data bytes and the checksum are 96.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Store ld_byte at ld_addr (only while idle) |
| ld_addr | input | 8 | Sector byte address |
| ld_byte | input | 8 | Sector byte to store |
| start | input | 1 | Begin one data field |
| wprot | input | 1 | Write-protect sense, sampled at start |
| cell_stb | input | 1 | One-cycle bit-cell strobe, at most one in four cycles |
| wr_en | output | 1 | High while the field's bits are on wr_bit |
| wr_bit | output | 1 | Serial data bit |
| busy | output | 1 | A field is in progress |
| done | output | 1 | One-cycle pulse when the field has ended |
| fault | output | 1 | One-cycle pulse when start met write protect |

## Verification
The bench goes after the hand-over points of the XOR chain:

- If the chain were not reset to zero, the first auxiliary byte would carry a stale value.
- If the auxiliary buffer were walked upward, the byte at the auxiliary-to-primary seam would be wrong.
- If the checksum were taken one entry early, the checksum would not match pri[255].

Bytes that set a single low bit at chosen addresses expose a loader that does not swap the two low bits or that puts a group in the wrong place. An all-FC sector forces the translation of 63 to appear, which catches an off-by-one table. Write-protect and mid-run start pulses check that a design does not leak bits or restart the sequence.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int SYM_W  = 6;
  localparam int NSYM   = 1 << SYM_W;
  localparam int SYNC_W = 10;

  typedef enum logic [3:0] {
    PH_IDLE, PH_GAP, PH_PRO, PH_AUX, PH_PRI, PH_SUM, PH_EPI, PH_TAIL, PH_END
  } phase_t;

  // Group-code table: ascending bytes with bit 7 set, no more than one
  // adjacent zero pair, and an adjacent one pair inside bits 6..0.
  function automatic logic [NSYM*8-1:0] build_gcr();
    logic [NSYM*8-1:0] t;
    logic [7:0] b;
    int k, zp, op;
    t = '0;
    k = 0;
    for (int v = 128; v < 256; v++) begin
      b  = 8'(v);
      zp = 0;
      op = 0;
      for (int i = 0; i < 7; i++) begin
        if (!b[i] && !b[i+1]) zp++;
        if (i < 6 && b[i] && b[i+1]) op++;
      end
      if (zp <= 1 && op >= 1 && k < NSYM) begin
        t[k*8 +: 8] = b;
        k++;
      end
    end
    return t;
  endfunction
endpackage

// File: rtl/sdf_buffers.sv
module sdf_buffers
  import sdf_pkg::*;
#(
  parameter int PRI_N = 256,
  parameter int AUX_N = 86,
  localparam int AW    = $clog2(PRI_N),
  localparam int XW    = $clog2(AUX_N),
  localparam int LANES = SYM_W / 2
) (
  input  logic             clk,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [7:0]       ld_byte,
  input  logic             rd_pri,
  input  logic [AW-1:0]    rd_idx,
  output logic [SYM_W-1:0] rd_sym
);
  logic [SYM_W-1:0] pri_mem [PRI_N];
  logic [SYM_W-1:0] pri_q;
  logic             sel_q;
  logic [SYM_W-1:0] aux_sym;

  always_ff @(posedge clk) begin
    if (ld_en) pri_mem[ld_addr] <= ld_byte[7:2];
    pri_q <= pri_mem[rd_idx];
    sel_q <= rd_pri;
  end

  // One two-bit lane per third of the sector; lane g feeds aux bits 2g+1:2g.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int BASE = g * AUX_N;
    logic [1:0]    mem [AUX_N];
    logic [1:0]    q;
    logic          live_q;
    logic          hit;
    logic [XW-1:0] off;

    assign off = XW'(ld_addr - AW'(BASE));
    assign hit = ld_en && (int'(ld_addr) >= BASE) && (int'(ld_addr) < BASE + AUX_N);

    always_ff @(posedge clk) begin
      if (hit) mem[off] <= {ld_byte[0], ld_byte[1]};
      q      <= mem[rd_idx[XW-1:0]];
      live_q <= (BASE + int'(rd_idx[XW-1:0])) < PRI_N;
    end

    assign aux_sym[2*g +: 2] = live_q ? q : 2'b00;
  end

  assign rd_sym = sel_q ? pri_q : aux_sym;
endmodule

// File: rtl/sdf_sequencer.sv
module sdf_sequencer
  import sdf_pkg::*;
#(
  parameter int PRI_N = 256,
  parameter int AUX_N = 86,
  parameter int GAP_N = 5,
  localparam int AW   = $clog2(PRI_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wprot,
  input  logic              take,
  input  logic              ser_end,
  input  logic [SYM_W-1:0]  rd_sym,
  output logic              rd_pri,
  output logic [AW-1:0]     rd_idx,
  output logic [SYNC_W-1:0] nxt_word,
  output logic              nxt_long,
  output logic              nxt_vld,
  output logic              finished,
  output logic              busy,
  output logic              done,
  output logic              fault
);
  localparam logic [NSYM*8-1:0] GCR       = build_gcr();
  localparam logic [23:0]       PRO_SEQ   = 24'hD5AAAD;
  localparam logic [23:0]       EPI_SEQ   = 24'hDEAAEB;
  localparam logic [SYNC_W-1:0] SYNC_WORD = 10'b11_1111_1100;

  function automatic logic [7:0] xl(input logic [SYM_W-1:0] s);
    return GCR[{s, 3'b000} +: 8];
  endfunction

  function automatic logic [7:0] pick3(input logic [23:0] w, input logic [AW-1:0] i);
    case (i)
      AW'(0):  return w[23:16];
      AW'(1):  return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  phase_t           ph;
  logic [AW-1:0]    cnt;
  logic [SYM_W-1:0] prev;
  logic             pend;

  assign rd_idx   = cnt;
  assign rd_pri   = (ph == PH_PRI);
  assign busy     = (ph != PH_IDLE);
  assign finished = (ph == PH_END) && !nxt_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      prev     <= '0;
      pend     <= 1'b0;
      nxt_vld  <= 1'b0;
      nxt_word <= '0;
      nxt_long <= 1'b0;
      done     <= 1'b0;
      fault    <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (take) nxt_vld <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          if (wprot) fault <= 1'b1;
          else begin
            ph  <= PH_GAP;
            cnt <= '0;
          end
        end
        PH_GAP: if (!nxt_vld) begin
          nxt_word <= SYNC_WORD;
          nxt_long <= 1'b1;
          nxt_vld  <= 1'b1;
          if (cnt == AW'(GAP_N - 1)) begin
            cnt <= '0;
            ph  <= PH_PRO;
          end else cnt <= cnt + AW'(1);
        end
        PH_PRO: if (!nxt_vld) begin
          nxt_word <= {pick3(PRO_SEQ, cnt), 2'b00};
          nxt_long <= 1'b0;
          nxt_vld  <= 1'b1;
          if (cnt == AW'(2)) begin
            cnt  <= AW'(AUX_N - 1);
            prev <= '0;
            ph   <= PH_AUX;
          end else cnt <= cnt + AW'(1);
        end
        PH_AUX, PH_PRI: begin
          if (pend) begin
            nxt_word <= {xl(rd_sym ^ prev), 2'b00};
            nxt_long <= 1'b0;
            nxt_vld  <= 1'b1;
            prev     <= rd_sym;
            pend     <= 1'b0;
            if (ph == PH_AUX) begin
              if (cnt == '0) ph <= PH_PRI;
              else cnt <= cnt - AW'(1);
            end else begin
              if (cnt == AW'(PRI_N - 1)) ph <= PH_SUM;
              else cnt <= cnt + AW'(1);
            end
          end else if (!nxt_vld) pend <= 1'b1;
        end
        PH_SUM: if (!nxt_vld) begin
          nxt_word <= {xl(prev), 2'b00};
          nxt_long <= 1'b0;
          nxt_vld  <= 1'b1;
          cnt      <= '0;
          ph       <= PH_EPI;
        end
        PH_EPI: if (!nxt_vld) begin
          nxt_word <= {pick3(EPI_SEQ, cnt), 2'b00};
          nxt_long <= 1'b0;
          nxt_vld  <= 1'b1;
          if (cnt == AW'(2)) ph <= PH_TAIL;
          else cnt <= cnt + AW'(1);
        end
        PH_TAIL: if (!nxt_vld) begin
          nxt_word <= SYNC_WORD;
          nxt_long <= 1'b1;
          nxt_vld  <= 1'b1;
          ph       <= PH_END;
        end
        PH_END: if (ser_end) begin
          ph   <= PH_IDLE;
          done <= 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdf_serializer.sv
module sdf_serializer
  import sdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cell_stb,
  input  logic [SYNC_W-1:0] nxt_word,
  input  logic              nxt_long,
  input  logic              nxt_vld,
  input  logic              finished,
  output logic              take,
  output logic              ser_end,
  output logic              wr_en,
  output logic              wr_bit
);
  logic [SYNC_W-1:0] sr;
  logic [3:0]        left;
  logic              slot_free;

  assign slot_free = cell_stb && run && (left == '0);
  assign take      = slot_free && nxt_vld;
  assign ser_end   = slot_free && !nxt_vld && finished;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      left   <= '0;
      wr_en  <= 1'b0;
      wr_bit <= 1'b0;
    end else if (cell_stb && run) begin
      if (left != '0) begin
        wr_bit <= sr[SYNC_W-1];
        sr     <= {sr[SYNC_W-2:0], 1'b0};
        left   <= left - 4'd1;
      end else if (nxt_vld) begin
        wr_bit <= nxt_word[SYNC_W-1];
        sr     <= {nxt_word[SYNC_W-2:0], 1'b0};
        left   <= nxt_long ? 4'(SYNC_W - 1) : 4'd7;
        wr_en  <= 1'b1;
      end else if (finished) begin
        wr_en  <= 1'b0;
        wr_bit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sector_data_encoder.sv
module sector_data_encoder
  import sdf_pkg::*;
#(
  parameter int PRI_N = 256,
  parameter int AUX_N = 86,
  parameter int GAP_N = 5,
  localparam int AW   = $clog2(PRI_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_byte,
  input  logic          start,
  input  logic          wprot,
  input  logic          cell_stb,
  output logic          wr_en,
  output logic          wr_bit,
  output logic          busy,
  output logic          done,
  output logic          fault
);
  logic              rd_pri;
  logic [AW-1:0]     rd_idx;
  logic [SYM_W-1:0]  rd_sym;
  logic [SYNC_W-1:0] nxt_word;
  logic              nxt_long, nxt_vld, finished, take, ser_end;

  sdf_buffers #(.PRI_N(PRI_N), .AUX_N(AUX_N)) u_buf (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_byte(ld_byte),
    .rd_pri(rd_pri), .rd_idx(rd_idx), .rd_sym(rd_sym)
  );

  sdf_sequencer #(.PRI_N(PRI_N), .AUX_N(AUX_N), .GAP_N(GAP_N)) u_seq (
    .clk(clk), .rst(rst), .start(start), .wprot(wprot), .take(take),
    .ser_end(ser_end), .rd_sym(rd_sym), .rd_pri(rd_pri), .rd_idx(rd_idx),
    .nxt_word(nxt_word), .nxt_long(nxt_long), .nxt_vld(nxt_vld),
    .finished(finished), .busy(busy), .done(done), .fault(fault)
  );

  sdf_serializer u_ser (
    .clk(clk), .rst(rst), .run(busy), .cell_stb(cell_stb),
    .nxt_word(nxt_word), .nxt_long(nxt_long), .nxt_vld(nxt_vld),
    .finished(finished), .take(take), .ser_end(ser_end),
    .wr_en(wr_en), .wr_bit(wr_bit)
  );
endmodule

// File: rtl/sdf_field_chk.sv
module sdf_field_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic wprot,
  input logic cell_stb,
  input logic wr_en,
  input logic wr_bit,
  input logic busy,
  input logic done,
  input logic fault
);
  // R1
  wp_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && wprot) |=> (fault && !busy && !wr_en));

  // R8
  cell_align_chk: assert property (@(posedge clk) disable iff (rst)
    !cell_stb |=> ($stable(wr_en) && $stable(wr_bit)));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wr_en && !busy));

  // R8
  frame_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  // R2
  sync_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> wr_bit);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !fault);
endmodule

bind sector_data_encoder sdf_field_chk u_chk (.*);

// File: tb/tb_sector_data_encoder.sv
module tb_sector_data_encoder;
  localparam int CLK_NS     = 10;
  localparam int BITS_TOTAL = 2852;
  localparam int NBYTES     = 349;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_en = 1'b0, start = 1'b0, wprot = 1'b0, cell_stb = 1'b0;
  logic [7:0] ld_addr = '0, ld_byte = '0;
  logic wr_en, wr_bit, busy, done, fault;

  sector_data_encoder dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_byte(ld_byte),
    .start(start), .wprot(wprot), .cell_stb(cell_stb), .wr_en(wr_en),
    .wr_bit(wr_bit), .busy(busy), .done(done), .fault(fault)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit cap_on = 1'b0;
  bit cap_q[$];
  bit fault_seen = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] tbl [64];
  logic [7:0] exp_b [NBYTES];

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void build_tbl();
    int k = 0;
    for (int v = 128; v < 256 && k < 64; v++) begin
      int zeros = 0, ones = 0;
      for (int i = 0; i < 7; i++) begin
        int pair = (v >> i) & 3;
        if (pair == 0) zeros++;
        if (pair == 3 && i < 6) ones++;
      end
      if (zeros < 2 && ones > 0) begin
        tbl[k] = 8'(v);
        k++;
      end
    end
  endfunction

  function automatic logic [1:0] swap2(input logic [7:0] b);
    return {b[0], b[1]};
  endfunction

  function automatic void build_expected();
    logic [5:0] aux [86];
    logic [5:0] prev;
    int p;
    for (int k = 0; k < 86; k++) begin
      aux[k][1:0] = swap2(mem[k]);
      aux[k][3:2] = swap2(mem[k+86]);
      aux[k][5:4] = (k + 172 < 256) ? swap2(mem[k+172]) : 2'b00;
    end
    exp_b[0] = 8'hD5; exp_b[1] = 8'hAA; exp_b[2] = 8'hAD;
    p = 3;
    prev = '0;
    for (int k = 85; k >= 0; k--) begin
      exp_b[p] = tbl[aux[k] ^ prev];
      prev = aux[k];
      p++;
    end
    for (int i = 0; i < 256; i++) begin
      exp_b[p] = tbl[mem[i][7:2] ^ prev];
      prev = mem[i][7:2];
      p++;
    end
    exp_b[p] = tbl[prev];
    exp_b[p+1] = 8'hDE; exp_b[p+2] = 8'hAA; exp_b[p+3] = 8'hEB;
  endfunction

  function automatic logic [7:0] got_byte(input int n);
    logic [7:0] b = '0;
    int pos = 50 + 8 * n;
    for (int i = 0; i < 8; i++)
      b = {b[6:0], (pos + i < cap_q.size()) ? cap_q[pos + i] : 1'b0};
    return b;
  endfunction

  function automatic bit sync_ok(input int pos);
    for (int i = 0; i < 10; i++) begin
      if (pos + i >= cap_q.size()) return 1'b0;
      if (cap_q[pos + i] != (i < 8)) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Bit-cell strobe every four cycles; capture one cycle after each strobe edge.
  initial begin
    forever begin
      @(negedge clk); cell_stb = 1'b1;
      @(negedge clk); cell_stb = 1'b0;
      if (cap_on && wr_en) cap_q.push_back(wr_bit);
      @(negedge clk);
      @(negedge clk);
    end
  end

  always @(posedge clk) if (fault) fault_seen <= 1'b1;

  task automatic load_mem();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a); ld_byte = mem[a];
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic section(input int lo, input int hi, input string req, input string what);
    int bad = 0, first = -1;
    for (int n = lo; n <= hi; n++)
      if (got_byte(n) !== exp_b[n]) begin
        bad++;
        if (first < 0) first = n;
      end
    if (first < 0) first = lo;
    check(bad == 0, req, what, int'(got_byte(first)), int'(exp_b[first]));
  endtask

  task automatic run_field(input string tag, input bit poke);
    bit seen = 1'b0;
    int n = 0;
    load_mem();
    build_expected();
    cap_q.delete();
    fault_seen = 1'b0;
    cap_on = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) fork
      begin
        repeat (3000) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    join_none
    while (n < 20000 && !seen) begin
      @(negedge clk); n++;
      if (done) seen = 1'b1;
    end
    cap_on = 1'b0;
    $display("run %s: %0d bits", tag, cap_q.size());
    check(seen, "R8", "done pulse", int'(seen), 1);
    check(!wr_en && !busy, "R8", "idle after done", int'({wr_en, busy}), 0);
    check(cap_q.size() == BITS_TOTAL, "R6", "bit count", cap_q.size(), BITS_TOTAL);
    check(sync_ok(0) && sync_ok(10) && sync_ok(20) && sync_ok(30) && sync_ok(40),
          "R2", "five leading syncs", 0, 1);
    section(0, 2, "R2", "prologue");
    section(3, 88, "R3", "auxiliary chain");
    section(89, 344, "R4", "primary chain");
    section(345, 345, "R6", "checksum");
    section(346, 348, "R6", "epilogue");
    check(sync_ok(50 + 8 * NBYTES), "R6", "trailing sync", 0, 1);
    if (poke) check(!fault_seen, "R9", "no fault on busy start", int'(fault_seen), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    build_tbl();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({wr_en, wr_bit, busy, done, fault} == 5'b0, "R8", "reset state",
          int'({wr_en, wr_bit, busy, done, fault}), 0);

    // R1: write protect at start
    wprot = 1'b1;
    cap_q.delete(); cap_on = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(fault == 1'b1, "R1", "fault pulse", int'(fault), 1);
    check(busy == 1'b0, "R1", "stays idle", int'(busy), 0);
    repeat (200) @(negedge clk);
    cap_on = 1'b0;
    check(cap_q.size() == 0 && !wr_en, "R1", "nothing written", cap_q.size(), 0);
    wprot = 1'b0;

    // R10: formatting pattern
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    run_field("zero", 1'b0);
    begin
      int bad = 0;
      for (int n = 3; n <= 345; n++) if (got_byte(n) != 8'h96) bad++;
      check(bad == 0, "R10", "all data bytes 96", bad, 0);
    end

    // R5: value 63 must translate to FF
    for (int a = 0; a < 256; a++) mem[a] = 8'hFC;
    run_field("fc", 1'b0);
    check(got_byte(89) == 8'hFF, "R5", "first primary byte", int'(got_byte(89)), 8'hFF);
    check(got_byte(3) == 8'h96, "R5", "first aux byte", int'(got_byte(3)), 8'h96);
    check(got_byte(345) == 8'hFF, "R5", "checksum of 63", int'(got_byte(345)), 8'hFF);

    // R7: low-bit placement and swap in the loader
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    mem[87] = 8'h01;
    mem[0]  = 8'h02;
    run_field("split", 1'b0);
    check(got_byte(87) == tbl[8], "R7", "aux entry 1 group 1", int'(got_byte(87)), int'(tbl[8]));
    check(got_byte(88) == tbl[9], "R7", "aux entry 0 seam", int'(got_byte(88)), int'(tbl[9]));
    check(got_byte(89) == tbl[1], "R7", "primary seam", int'(got_byte(89)), int'(tbl[1]));

    // R3 R4: random and ramp data, with a mid-run start for R9
    for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
    run_field("rand1", 1'b1);
    for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
    run_field("rand2", 1'b0);
    for (int a = 0; a < 256; a++) mem[a] = 8'(a);
    run_field("ramp", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule